// File: doc/BRIEF.md
# Oversampling Serial Receiver with Two-Entry Buffer

This block receives asynchronous serial characters from a single line. Every cycle in which `baud_tick` is high the line is sampled once, and a character is built from those samples. In normal mode there are sixteen samples per bit, and with `dbl_speed` high there are eight. The sample counter is restarted by the falling edge that opens each frame, so the bit timing follows the sender. Each bit, the start bit included, is decided by a two-of-three vote over the samples at its centre. A single short glitch therefore cannot flip a bit.

Optional parity is checked, and the stop bit is checked for a framing error. The character and its two error flags are written together into a small receive buffer. The host sees the character at the head of the buffer with its own flags. It pops that character with `rd_stb`, and `rx_ready` stays high while anything is left unread. Dropping `rx_en` aborts any frame in progress and empties the buffer in the same clock.

The receive state machine has five states:
- `RX_IDLE` waits for a low sample. The transition *edge-seen* goes to `RX_START`.
- `RX_START` votes on the start bit. *False-start* returns to `RX_IDLE` if the vote is high. *Start-ok* moves to `RX_DATA` at the end of the bit.
- `RX_DATA` shifts in the data bits, least significant first. After the last one, *to-parity* goes to `RX_PAR` if parity was enabled at the start bit, and *to-stop* goes to `RX_STOP` otherwise.
- `RX_PAR` takes one bit, then *par-done* goes to `RX_STOP`.
- `RX_STOP` decides the stop bit at its vote sample, pushes the character, and takes *frame-done* back to `RX_IDLE`.

Any state takes *abort* to `RX_IDLE` while `rx_en` is low.

Top module: `uart_rx_os`

## Requirements
- R1: The line idles high. A frame is a low start bit, DATA_W data bits least significant first, an optional parity bit and one stop bit. One line sample is taken per clock with `baud_tick` high.
- R2: Sample 1 is the first tick on which the line is seen low. Each bit's value is the majority of its samples 8, 9 and 10 (16x mode) or 4, 5 and 6 (8x mode). One corrupted sample in a bit does not change the received data.
- R3: With `dbl_speed`=1 a bit lasts 8 samples, otherwise 16. The mode is captured at the start edge of each frame.
- R4: If the majority of the start-bit centre samples is high, the frame is dropped and the receiver waits for the next low sample. Nothing is stored.
- R5: With parity on, `par_odd`=0 selects even parity: the XOR of the data bits and the parity bit must be 0. `par_odd`=1 selects odd parity: that XOR must be 1. On a mismatch `par_err` is high while that character is at the head, until it is read. Each character keeps its own flag.
- R6: `par_en` and `par_odd` are captured at the start edge. Changing them during a frame does not affect that frame.
- R7: A stop bit voted low sets `frm_err` for that character while it is at the head.
- R8: `rx_ready` is high while the buffer holds an unread character. `rd_data` shows the oldest one. `rd_stb` for one cycle removes it, and `rd_stb` on an empty buffer does nothing.
- R9: The buffer holds FIFO_DEPTH (2) characters. A character that completes while the buffer is full is dropped and sets `overrun`. `overrun` clears on an accepted read or when the receiver is disabled.
- R10: With `rx_en` low at a clock edge, the buffer is empty, all flags are low and any partial frame is discarded after that edge.
- R11: Line activity while `rx_en` is low produces no character.
- R12: After reset `rx_ready`, `par_err`, `frm_err` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low flushes and aborts |
| dbl_speed | input | 1 | 1 = 8 samples per bit, 0 = 16 |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| baud_tick | input | 1 | One line sample per high cycle |
| rxd | input | 1 | Serial line, asynchronous |
| rd_stb | input | 1 | Pop the head character |
| rd_data | output | DATA_W | Head character (0 when empty) |
| rx_ready | output | 1 | Buffer holds an unread character |
| par_err | output | 1 | Parity error of the head character |
| frm_err | output | 1 | Framing error of the head character |
| overrun | output | 1 | A character was dropped on a full buffer |

## Verification
The line passes through two synchronizer flops. The stop-bit vote falls on sample 10 (or 6) of the stop bit, and the push to the buffer and the buffer write each add one register. A character therefore appears about four clocks after its stop-bit vote sample. In 8x mode with a tick every clock, that point lies after the nominal end of the stop bit. The bench always holds the line idle for twelve clocks after a frame before it samples, and it samples on falling edges. A read or a disable acts at the next rising edge, so those results are checked at the falling edge that follows it.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= 1'b1;
                else        pipe <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= {pipe[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_NORM = 16,
    parameter int OS_DBL  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              tick,
    input  logic              line,
    input  logic              dbl_speed,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              push_pe,
    output logic              push_fe
);
    localparam int CNT_W = $clog2(OS_NORM + 1);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_t         state, nxt;
    logic [CNT_W-1:0]  smp_cnt, smp_next, os_len, mid;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              dbl_q, par_q, odd_q, par_acc;
    logic              s_a, s_b, vote;
    logic              at_first, at_mid, at_vote, at_end, last_bit;

    // timing within one bit
    always_comb begin
        os_len   = dbl_q ? CNT_W'(OS_DBL) : CNT_W'(OS_NORM);
        mid      = (os_len >> 1) + CNT_W'(1);
        smp_next = smp_cnt + CNT_W'(1);
        at_first = (smp_next == mid - CNT_W'(1));
        at_mid   = (smp_next == mid);
        at_vote  = (smp_next == mid + CNT_W'(1));
        at_end   = (smp_next == os_len);
        last_bit = (bit_idx == BIT_W'(DATA_W - 1));
        vote     = maj3(s_a, s_b, line);
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (tick && !line) nxt = RX_START;
            RX_START: begin
                if (tick && at_vote && vote) nxt = RX_IDLE;
                else if (tick && at_end)     nxt = RX_DATA;
            end
            RX_DATA:  if (tick && at_end && last_bit) nxt = par_q ? RX_PAR : RX_STOP;
            RX_PAR:   if (tick && at_end)  nxt = RX_STOP;
            RX_STOP:  if (tick && at_vote) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= RX_IDLE;
        else if (!rx_en) state <= RX_IDLE;
        else             state <= nxt;
    end

    // sample datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_cnt <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            dbl_q   <= 1'b0;
            par_q   <= 1'b0;
            odd_q   <= 1'b0;
            par_acc <= 1'b0;
            s_a     <= 1'b1;
            s_b     <= 1'b1;
        end else if (!rx_en) begin
            smp_cnt <= '0;
            bit_idx <= '0;
            par_acc <= 1'b0;
        end else if (tick) begin
            if (state == RX_IDLE) begin
                if (!line) begin
                    smp_cnt <= CNT_W'(1);
                    bit_idx <= '0;
                    par_acc <= 1'b0;
                    dbl_q   <= dbl_speed;
                    par_q   <= par_en;
                    odd_q   <= par_odd;
                end
            end else begin
                smp_cnt <= at_end ? '0 : smp_next;
                if (at_first) s_a <= line;
                if (at_mid)   s_b <= line;
                if (state == RX_DATA) begin
                    if (at_vote) begin
                        shreg   <= {vote, shreg[DATA_W-1:1]};
                        par_acc <= par_acc ^ vote;
                    end
                    if (at_end) bit_idx <= bit_idx + BIT_W'(1);
                end
                if (state == RX_PAR && at_vote) par_acc <= par_acc ^ vote;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push      <= 1'b0;
            push_data <= '0;
            push_pe   <= 1'b0;
            push_fe   <= 1'b0;
        end else begin
            push <= rx_en && tick && (state == RX_STOP) && at_vote;
            if (rx_en && tick && (state == RX_STOP) && at_vote) begin
                push_data <= shreg;
                push_pe   <= par_q && (par_acc != odd_q);
                push_fe   <= !vote;
            end
        end
    end
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       push_pe,
    input  logic                       push_fe,
    input  logic                       pop,
    output logic [DATA_W-1:0]          head_data,
    output logic                       head_pe,
    output logic                       head_fe,
    output logic                       not_empty,
    output logic                       dropped,
    output logic                       popped,
    output logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem_d  [DEPTH];
    logic [DEPTH-1:0]  mem_pe, mem_fe;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt;
    logic              do_rd, do_wr;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign do_rd   = pop && (cnt != '0);
    assign do_wr   = push && ((cnt != CNT_W'(DEPTH)) || do_rd);
    assign dropped = push && !do_wr && !flush;
    assign popped  = do_rd && !flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_wr) wr_ptr <= adv(wr_ptr);
            if (do_rd) rd_ptr <= adv(rd_ptr);
            if (do_wr && !do_rd)      cnt <= cnt + CNT_W'(1);
            else if (do_rd && !do_wr) cnt <= cnt - CNT_W'(1);
        end
    end

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_d[e]  <= '0;
                    mem_pe[e] <= 1'b0;
                    mem_fe[e] <= 1'b0;
                end else if (!flush && do_wr && wr_ptr == PTR_W'(e)) begin
                    mem_d[e]  <= push_data;
                    mem_pe[e] <= push_pe;
                    mem_fe[e] <= push_fe;
                end
            end
        end
    endgenerate

    assign not_empty = (cnt != '0);
    assign head_data = not_empty ? mem_d[rd_ptr] : '0;
    assign head_pe   = not_empty && mem_pe[rd_ptr];
    assign head_fe   = not_empty && mem_fe[rd_ptr];
    assign fill      = cnt;
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os #(
    parameter int DATA_W      = 8,
    parameter int FIFO_DEPTH  = 2,
    parameter int OS_NORM     = 16,
    parameter int OS_DBL      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              dbl_speed,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              baud_tick,
    input  logic              rxd,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_ready,
    output logic              par_err,
    output logic              frm_err,
    output logic              overrun
);
    localparam int FILL_W = $clog2(FIFO_DEPTH + 1);

    logic              line_s;
    logic              push, push_pe, push_fe;
    logic [DATA_W-1:0] push_data;
    logic              dropped, popped;
    logic [FILL_W-1:0] fifo_cnt;

    rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
    );

    rx_frame_fsm #(.DATA_W(DATA_W), .OS_NORM(OS_NORM), .OS_DBL(OS_DBL)) i_fsm (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(baud_tick), .line(line_s),
        .dbl_speed(dbl_speed), .par_en(par_en), .par_odd(par_odd),
        .push(push), .push_data(push_data), .push_pe(push_pe), .push_fe(push_fe)
    );

    rx_char_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .flush(!rx_en),
        .push(push), .push_data(push_data), .push_pe(push_pe), .push_fe(push_fe),
        .pop(rd_stb), .head_data(rd_data), .head_pe(par_err), .head_fe(frm_err),
        .not_empty(rx_ready), .dropped(dropped), .popped(popped), .fill(fifo_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       overrun <= 1'b0;
        else if (!rx_en)  overrun <= 1'b0;
        else if (dropped) overrun <= 1'b1;
        else if (popped)  overrun <= 1'b0;
    end
endmodule

// File: rtl/uart_rx_os_chk.sv
module uart_rx_os_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rx_en,
    input logic                       rd_stb,
    input logic [DATA_W-1:0]          rd_data,
    input logic                       rx_ready,
    input logic                       par_err,
    input logic                       frm_err,
    input logic                       overrun,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_ready);

    a_r10_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!overrun && !par_err && !frm_err));

    a_r5_pe_has_char: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> rx_ready);

    a_r7_fe_has_char: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err |-> rx_ready);

    a_r8_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_ready && !rd_stb) |=> ($stable(rd_data) && $stable(par_err) && $stable(frm_err)));

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= DEPTH);

    a_r9_overrun_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(fifo_cnt) == DEPTH));
endmodule

bind uart_rx_os uart_rx_os_chk #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) i_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_stb(rd_stb), .rd_data(rd_data),
    .rx_ready(rx_ready), .par_err(par_err), .frm_err(frm_err), .overrun(overrun),
    .fifo_cnt(fifo_cnt)
);

// File: tb/test_uart_rx_os.sv
`timescale 1ns/1ps
module test_uart_rx_os;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, dbl_speed = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic       baud_tick = 1'b0, rxd = 1'b1, rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       rx_ready, par_err, frm_err, overrun;

    int checks = 0, failures = 0, cyc = 0;
    int tick_div = 1, tdiv = 0, bit_cyc = 16;
    bit done = 0;

    always #2 clk = ~clk;

    uart_rx_os i_uart_rx_os (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .dbl_speed(dbl_speed),
        .par_en(par_en), .par_odd(par_odd), .baud_tick(baud_tick), .rxd(rxd),
        .rd_stb(rd_stb), .rd_data(rd_data), .rx_ready(rx_ready),
        .par_err(par_err), .frm_err(frm_err), .overrun(overrun)
    );

    always @(negedge clk) begin
        if (tdiv >= tick_div - 1) begin tdiv = 0; baud_tick = 1'b1; end
        else begin tdiv = tdiv + 1; baud_tick = 1'b0; end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // glitch_bit >= 0 flips one clock near the centre of that data bit
    task automatic send_frame(input logic [7:0] d, input bit with_par, input bit pbit,
                              input bit stop_v, input int glitch_bit);
        rxd = 1'b0; idle(bit_cyc);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            if (i == glitch_bit) begin
                idle(bit_cyc / 2); rxd = ~d[i]; idle(1); rxd = d[i];
                idle(bit_cyc - bit_cyc / 2 - 1);
            end else idle(bit_cyc);
        end
        if (with_par) begin rxd = pbit; idle(bit_cyc); end
        rxd = stop_v; idle(bit_cyc);
        rxd = 1'b1; idle(12);
    endtask

    task automatic rd_one;
        rd_stb = 1'b1; idle(1); rd_stb = 1'b0;
    endtask

    task automatic t_reset;
        chk("R12 rx_ready", rx_ready, 0);
        chk("R12 par_err", par_err, 0);
        chk("R12 frm_err", frm_err, 0);
        chk("R12 overrun", overrun, 0);
    endtask

    task automatic t_basic16;
        send_frame(8'hA5, 0, 0, 1, -1);
        chk("R1 ready", rx_ready, 1);
        chk("R1 data", rd_data, 8'hA5);
        chk("R7 no fe", frm_err, 0);
        rd_one;
        chk("R8 empty after read", rx_ready, 0);
        rd_one;
        chk("R8 read on empty", rx_ready, 0);
        chk("R8 empty data", rd_data, 0);
    endtask

    task automatic t_slow_tick;
        tick_div = 2; bit_cyc = 32;
        send_frame(8'h6E, 0, 0, 1, -1);
        chk("R1 ticked data", rd_data, 8'h6E);
        rd_one;
        tick_div = 1; bit_cyc = 16;
    endtask

    task automatic t_double;
        dbl_speed = 1'b1; bit_cyc = 8;
        send_frame(8'h3C, 0, 0, 1, -1);
        chk("R3 8x data", rd_data, 8'h3C);
        rd_one;
        send_frame(8'h81, 0, 0, 1, 6);
        chk("R2 8x glitch data", rd_data, 8'h81);
        rd_one;
        dbl_speed = 1'b0; bit_cyc = 16;
    endtask

    task automatic t_glitch;
        send_frame(8'h0F, 0, 0, 1, 2);
        chk("R2 glitch data", rd_data, 8'h0F);
        rd_one;
    endtask

    task automatic t_false_start;
        rxd = 1'b0; idle(3); rxd = 1'b1; idle(40);
        chk("R4 no char", rx_ready, 0);
        send_frame(8'h5A, 0, 0, 1, -1);
        chk("R4 next frame ok", rd_data, 8'h5A);
        rd_one;
    endtask

    task automatic t_parity;
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'h07, 1, ^8'h07, 1, -1);   // correct even
        send_frame(8'h07, 1, ~^8'h07, 1, -1);  // wrong even
        chk("R5 even ok data", rd_data, 8'h07);
        chk("R5 even ok pe", par_err, 0);
        rd_one;
        chk("R5 even bad pe", par_err, 1);
        rd_one;
        chk("R5 pe gone after read", par_err, 0);
        par_odd = 1'b1;
        send_frame(8'hC3, 1, ^8'hC3, 1, -1);   // wrong odd
        send_frame(8'hC3, 1, ~^8'hC3, 1, -1);  // correct odd
        chk("R5 odd bad pe", par_err, 1);
        rd_one;
        chk("R5 odd ok pe", par_err, 0);
        rd_one;
        par_odd = 1'b0;
    endtask

    task automatic t_par_latched;
        par_en = 1'b1; par_odd = 1'b0;
        fork
            send_frame(8'h33, 1, ~^8'h33, 1, -1);
            begin idle(40); par_en = 1'b0; end
        join
        chk("R6 data", rd_data, 8'h33);
        chk("R6 pe kept", par_err, 1);
        rd_one;
        par_en = 1'b0;
    endtask

    task automatic t_frame_err;
        send_frame(8'h99, 0, 0, 0, -1);
        idle(40);
        chk("R7 fe", frm_err, 1);
        chk("R7 data", rd_data, 8'h99);
        rd_one;
        chk("R7 empty", rx_ready, 0);
    endtask

    task automatic t_overrun;
        send_frame(8'h11, 0, 0, 1, -1);
        send_frame(8'h22, 0, 0, 1, -1);
        chk("R9 no ovr yet", overrun, 0);
        send_frame(8'h33, 0, 0, 1, -1);
        chk("R9 ovr", overrun, 1);
        chk("R9 head", rd_data, 8'h11);
        rd_one;
        chk("R9 second", rd_data, 8'h22);
        chk("R9 ovr cleared", overrun, 0);
        rd_one;
        chk("R9 third dropped", rx_ready, 0);
    endtask

    task automatic t_flush;
        send_frame(8'h44, 0, 0, 1, -1);
        send_frame(8'h55, 0, 0, 1, -1);
        send_frame(8'h66, 0, 0, 1, -1);
        rx_en = 1'b0; idle(1);
        chk("R10 flushed", rx_ready, 0);
        chk("R10 ovr cleared", overrun, 0);
        send_frame(8'h77, 0, 0, 1, -1);
        rx_en = 1'b1; idle(40);
        chk("R11 ignored while off", rx_ready, 0);
        rxd = 1'b0; idle(bit_cyc);
        rxd = 1'b1; idle(bit_cyc); rxd = 1'b0; idle(bit_cyc);
        rx_en = 1'b0; idle(1);
        rxd = 1'b1; idle(bit_cyc * 8);
        rx_en = 1'b1; idle(60);
        chk("R10 partial discarded", rx_ready, 0);
        send_frame(8'hE1, 0, 0, 1, -1);
        chk("R10 resumes", rd_data, 8'hE1);
        rd_one;
    endtask

    initial begin
        idle(4);
        t_reset;
        rst_n = 1'b1; idle(2);
        rx_en = 1'b1; idle(20);
        t_basic16;
        t_slow_tick;
        t_double;
        t_glitch;
        t_false_start;
        t_parity;
        t_par_latched;
        t_frame_err;
        t_overrun;
        t_flush;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule